// File: doc/BRIEF.md
# Linear Frequency Sweep Controller

This block produces the frequency tuning word and the phase offset that feed a numerically controlled oscillator. It runs on the divided synchronization clock. It holds no registers of its own for the profiles. The profile contents, the profile select and two mode bits arrive as inputs. Its outputs are registered, so every change at the inputs shows up one clock later.

With sweeping off, the block passes on the tuning word and the phase word of the profile that the select picks. With sweeping on, the tuning word moves in steps between a lower limit, taken from profile 0, and an upper limit, taken from profile 1. The step size and the step interval are set separately for the rising and the falling direction, and select bit 0 chooses the direction. In the no-dwell variant, select bit 0 acts as a trigger instead. A rising edge on it starts one upward sweep that cannot be interrupted. When that sweep reaches the upper limit, a one-clock done pulse is raised and the word drops back to the lower limit.

Top module: `fsweep_ctrl`

## Requirements
- R1: With the sweep-enable input low, the tuning-word output equals the tuning word of the profile picked by the select input, one clock after the select is presented.
- R2: In every mode, the phase output equals the phase word of the selected profile, one clock after the select is presented, so frequency and phase always come from the same profile.
- R3: Reset, entry into default sweep mode (sweep enable 1, no-dwell 0) and entry into no-dwell mode (both 1) each load the tuning-word output with the profile 0 word, which is the lower limit.
- R4: In default sweep mode with select bit 0 at 1, the output grows by the rising delta every rising-rate clocks. The first step comes on the rate-th clock after entry or after a direction change.
- R5: In default sweep mode with select bit 0 at 0, the output shrinks by the falling delta every falling-rate clocks.
- R6: The output never passes the profile 1 word (upper limit) or the profile 0 word (lower limit). A step that would overshoot stops at the limit, and the output holds there while select bit 0 stays unchanged.
- R7: A change of select bit 0 during a ramp restarts the interval count and continues from the present value in the new direction, using that direction's delta and rate.
- R8: A rate value of 0 behaves as 1, giving one step on every clock.
- R9: In no-dwell mode, a low-to-high edge of select bit 0 starts a sweep that steps by the rising delta every rising-rate clocks. The first step comes rate clocks after the edge is taken. The sweep runs to the end even if select bit 0 falls.
- R10: When a no-dwell step reaches or passes the upper limit, the output shows the upper limit for one clock with the done output at 1. On the next clock the output returns to the lower limit and done returns to 0. Done is 0 at all other times.
- R11: In no-dwell mode, holding select bit 0 high never starts a second sweep. A new sweep needs select bit 0 to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synchronization clock |
| rst | input | 1 | Synchronous active-high reset |
| prof_ftw | input | NPROF*FTW_W | Profile tuning words; profile i occupies bits [i*FTW_W +: FTW_W] |
| prof_pow | input | NPROF*POW_W | Profile phase words; profile i occupies bits [i*POW_W +: POW_W] |
| prof_sel | input | SEL_W | Active profile; bit 0 is also the sweep direction (1 = up) or the trigger |
| sweep_en | input | 1 | 1 enables sweeping |
| no_dwell | input | 1 | With sweep_en, selects the triggered one-shot upward sweep |
| rise_delta | input | FTW_W | Step added on each rising step |
| fall_delta | input | FTW_W | Step subtracted on each falling step |
| rise_rate | input | RATE_W | Clocks per rising step (0 acts as 1) |
| fall_rate | input | RATE_W | Clocks per falling step (0 acts as 1) |
| ftw_out | output | FTW_W | Registered tuning word |
| pow_out | output | POW_W | Registered phase word |
| sweep_done | output | 1 | One-clock pulse when a no-dwell sweep reaches the upper limit |

## Verification
The bench builds the block with 16-bit tuning words, 8-bit phase words, eight profiles and an 8-bit rate counter. The limits are set 100 apart and the deltas are tens, so each sweep saturates after a few steps. Both limits, the snap-back, a mid-ramp reversal and the rate-zero case therefore each take only a few dozen clocks. Because the rates are small, the expected step cycles can be written down one by one. This checks the exact clock on which each step lands, not just the values the output reaches.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

  typedef enum logic [1:0] {
    MODE_TONE    = 2'd0,
    MODE_SWEEP   = 2'd1,
    MODE_NODWELL = 2'd2
  } fsw_mode_e;

  typedef enum logic [1:0] {
    ND_IDLE = 2'd0,
    ND_RUN  = 2'd1,
    ND_SNAP = 2'd2
  } nd_state_e;

endpackage

// File: rtl/fsw_profile_mux.sv
module fsw_profile_mux #(
  parameter int NPROF = 8,
  parameter int FTW_W = 48,
  parameter int POW_W = 14,
  localparam int SEL_W = $clog2(NPROF)
) (
  input  logic [NPROF*FTW_W-1:0] prof_ftw,
  input  logic [NPROF*POW_W-1:0] prof_pow,
  input  logic [SEL_W-1:0]       sel,
  output logic [FTW_W-1:0]       sel_ftw,
  output logic [POW_W-1:0]       sel_pow,
  output logic [FTW_W-1:0]       lo_ftw,
  output logic [FTW_W-1:0]       hi_ftw
);

  logic [FTW_W-1:0] ftw_arr [NPROF];
  logic [POW_W-1:0] pow_arr [NPROF];

  for (genvar i = 0; i < NPROF; i++) begin : g_split
    assign ftw_arr[i] = prof_ftw[i*FTW_W +: FTW_W];
    assign pow_arr[i] = prof_pow[i*POW_W +: POW_W];
  end

  assign sel_ftw = ftw_arr[sel];
  assign sel_pow = pow_arr[sel];
  assign lo_ftw  = ftw_arr[0];
  assign hi_ftw  = ftw_arr[1];

endmodule

// File: rtl/fsw_rate_timer.sv
module fsw_rate_timer #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);

  logic [RATE_W-1:0] cnt;
  logic [RATE_W-1:0] rate_eff;
  logic [RATE_W-1:0] cnt_use;

  assign rate_eff = (rate == '0) ? RATE_W'(1) : rate;
  assign cnt_use  = restart ? '0 : cnt;
  assign tick     = run && (cnt_use == rate_eff - RATE_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_use + RATE_W'(1);
    end
  end

  // R8: a zero rate steps on every running clock
  p_rate_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (run && rate == '0) |-> tick);

  // R4: after a step the interval count starts over
  p_count_restart_r4: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == '0));

endmodule

// File: rtl/fsw_step_unit.sv
module fsw_step_unit #(
  parameter int FTW_W = 48
) (
  input  logic [FTW_W-1:0] cur,
  input  logic [FTW_W-1:0] delta,
  input  logic [FTW_W-1:0] lo,
  input  logic [FTW_W-1:0] hi,
  input  logic             up,
  output logic [FTW_W-1:0] nxt,
  output logic             reach
);

  logic [FTW_W:0] sum;
  logic [FTW_W:0] diff;

  assign sum  = {1'b0, cur} + {1'b0, delta};
  assign diff = {1'b0, cur} - {1'b0, delta};

  always_comb begin
    if (up) begin
      if (sum >= {1'b0, hi}) begin
        nxt   = hi;
        reach = 1'b1;
      end else begin
        nxt   = sum[FTW_W-1:0];
        reach = 1'b0;
      end
    end else begin
      if (diff[FTW_W] || (diff[FTW_W-1:0] <= lo)) begin
        nxt   = lo;
        reach = 1'b1;
      end else begin
        nxt   = diff[FTW_W-1:0];
        reach = 1'b0;
      end
    end
  end

endmodule

// File: rtl/fsweep_ctrl.sv
module fsweep_ctrl #(
  parameter int NPROF  = 8,
  parameter int FTW_W  = 48,
  parameter int POW_W  = 14,
  parameter int RATE_W = 16,
  localparam int SEL_W = $clog2(NPROF)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPROF*FTW_W-1:0] prof_ftw,
  input  logic [NPROF*POW_W-1:0] prof_pow,
  input  logic [SEL_W-1:0]       prof_sel,
  input  logic                   sweep_en,
  input  logic                   no_dwell,
  input  logic [FTW_W-1:0]       rise_delta,
  input  logic [FTW_W-1:0]       fall_delta,
  input  logic [RATE_W-1:0]      rise_rate,
  input  logic [RATE_W-1:0]      fall_rate,
  output logic [FTW_W-1:0]       ftw_out,
  output logic [POW_W-1:0]       pow_out,
  output logic                   sweep_done
);

  import fsw_pkg::*;

  logic [FTW_W-1:0] sel_ftw, lo_ftw, hi_ftw;
  logic [POW_W-1:0] sel_pow;

  fsw_profile_mux #(
    .NPROF(NPROF), .FTW_W(FTW_W), .POW_W(POW_W)
  ) u_mux (
    .prof_ftw(prof_ftw),
    .prof_pow(prof_pow),
    .sel     (prof_sel),
    .sel_ftw (sel_ftw),
    .sel_pow (sel_pow),
    .lo_ftw  (lo_ftw),
    .hi_ftw  (hi_ftw)
  );

  fsw_mode_e mode, mode_q;
  nd_state_e nd_st;
  logic      dir, dir_q, s0_q;
  logic      entry, at_lim, start;
  logic      tmr_run, tmr_restart, tick;
  logic      step_up, reach;
  logic [RATE_W-1:0] rate_mux;
  logic [FTW_W-1:0]  delta_mux, nxt;

  assign mode  = !sweep_en ? MODE_TONE : (no_dwell ? MODE_NODWELL : MODE_SWEEP);
  assign dir   = prof_sel[0];
  assign entry = (mode != mode_q) && (mode != MODE_TONE);

  assign at_lim = dir ? (ftw_out >= hi_ftw) : (ftw_out <= lo_ftw);
  assign start  = (mode == MODE_NODWELL) && !entry && (nd_st == ND_IDLE)
                  && dir && !s0_q;

  always_comb begin
    if (mode == MODE_SWEEP) begin
      tmr_run     = !entry && !at_lim;
      tmr_restart = (dir != dir_q);
      step_up     = dir;
    end else if (mode == MODE_NODWELL) begin
      tmr_run     = !entry && (nd_st == ND_RUN);
      tmr_restart = 1'b0;
      step_up     = 1'b1;
    end else begin
      tmr_run     = 1'b0;
      tmr_restart = 1'b0;
      step_up     = 1'b1;
    end
    rate_mux  = step_up ? rise_rate  : fall_rate;
    delta_mux = step_up ? rise_delta : fall_delta;
  end

  fsw_rate_timer #(.RATE_W(RATE_W)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .run    (tmr_run),
    .restart(tmr_restart),
    .rate   (rate_mux),
    .tick   (tick)
  );

  fsw_step_unit #(.FTW_W(FTW_W)) u_step (
    .cur  (ftw_out),
    .delta(delta_mux),
    .lo   (lo_ftw),
    .hi   (hi_ftw),
    .up   (step_up),
    .nxt  (nxt),
    .reach(reach)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_out    <= lo_ftw;
      pow_out    <= '0;
      sweep_done <= 1'b0;
      mode_q     <= MODE_TONE;
      nd_st      <= ND_IDLE;
      dir_q      <= 1'b0;
      s0_q       <= 1'b0;
    end else begin
      mode_q     <= mode;
      dir_q      <= dir;
      s0_q       <= dir;
      pow_out    <= sel_pow;
      sweep_done <= 1'b0;
      case (mode)
        MODE_SWEEP: begin
          nd_st <= ND_IDLE;
          if (entry) ftw_out <= lo_ftw;
          else if (tick) ftw_out <= nxt;
        end
        MODE_NODWELL: begin
          if (entry) begin
            ftw_out <= lo_ftw;
            nd_st   <= ND_IDLE;
          end else begin
            case (nd_st)
              ND_IDLE: if (start) nd_st <= ND_RUN;
              ND_RUN: begin
                if (tick) begin
                  ftw_out <= nxt;
                  if (reach) begin
                    nd_st      <= ND_SNAP;
                    sweep_done <= 1'b1;
                  end
                end
              end
              default: begin
                ftw_out <= lo_ftw;
                nd_st   <= ND_IDLE;
              end
            endcase
          end
        end
        default: begin
          nd_st   <= ND_IDLE;
          ftw_out <= sel_ftw;
        end
      endcase
    end
  end

  // R1: single tone follows the selected profile
  p_tone_ftw_r1: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_TONE) |=> (ftw_out == $past(sel_ftw)));

  // R2: phase always from the selected profile
  p_phase_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (pow_out == $past(sel_pow)));

  // R3: entering a sweep mode loads the lower limit
  p_entry_lo_r3: assert property (@(posedge clk) disable iff (rst)
    entry |=> (ftw_out == $past(lo_ftw)));

  // R6: at a limit in the present direction the word holds
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SWEEP && !entry && at_lim) |=> $stable(ftw_out));

  // R10: done marks the upper limit, lasts one clock, then snap back
  p_done_upper_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(sweep_done) |-> (ftw_out == $past(hi_ftw)));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    sweep_done |=> !sweep_done);
  p_snap_r10: assert property (@(posedge clk) disable iff (rst)
    (sweep_done && mode == MODE_NODWELL) |=> (ftw_out == $past(lo_ftw)));

  // R11: no sweep starts without a fresh edge
  p_fresh_edge_r11: assert property (@(posedge clk) disable iff (rst)
    (nd_st == ND_IDLE && s0_q) |=> (nd_st != ND_RUN));

endmodule

// File: tb/sim_fsweep_ctrl.sv
module sim_fsweep_ctrl;

  localparam int CLK_PER = 10;
  localparam int NPROF  = 8;
  localparam int FTW_W  = 16;
  localparam int POW_W  = 8;
  localparam int RATE_W = 8;
  localparam int SEL_W  = $clog2(NPROF);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NPROF*FTW_W-1:0] prof_ftw;
  logic [NPROF*POW_W-1:0] prof_pow;
  logic [SEL_W-1:0] prof_sel = '0;
  logic sweep_en = 1'b0, no_dwell = 1'b0;
  logic [FTW_W-1:0] rise_delta = '0, fall_delta = '0;
  logic [RATE_W-1:0] rise_rate = '0, fall_rate = '0;
  logic [FTW_W-1:0] ftw_out;
  logic [POW_W-1:0] pow_out;
  logic sweep_done;

  logic [FTW_W-1:0] ftw_tab [NPROF];
  logic [POW_W-1:0] pow_tab [NPROF];

  fsweep_ctrl #(.NPROF(NPROF), .FTW_W(FTW_W), .POW_W(POW_W), .RATE_W(RATE_W)) u0 (
    .clk(clk), .rst(rst), .prof_ftw(prof_ftw), .prof_pow(prof_pow),
    .prof_sel(prof_sel), .sweep_en(sweep_en), .no_dwell(no_dwell),
    .rise_delta(rise_delta), .fall_delta(fall_delta),
    .rise_rate(rise_rate), .fall_rate(fall_rate),
    .ftw_out(ftw_out), .pow_out(pow_out), .sweep_done(sweep_done)
  );

  always #(CLK_PER/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int               at;
    logic [FTW_W-1:0] ftw;
    logic [POW_W-1:0] pow;
    bit               chk_pow;
    logic             dn;
    string            req;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic push(int at, logic [FTW_W-1:0] f, logic dn, string req);
    exp_t e;
    e.at = at; e.ftw = f; e.pow = '0; e.chk_pow = 1'b0; e.dn = dn; e.req = req;
    sb.push_back(e);
  endtask

  task automatic push_pow(int at, logic [FTW_W-1:0] f, logic [POW_W-1:0] p, string req);
    exp_t e;
    e.at = at; e.ftw = f; e.pow = p; e.chk_pow = 1'b1; e.dn = 1'b0; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: compare at the falling edge, away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.at != cyc) begin
        failures++;
        $display("FAIL %s: item for cycle %0d missed (now %0d)", e.req, e.at, cyc);
      end else if (ftw_out !== e.ftw || sweep_done !== e.dn ||
                   (e.chk_pow && pow_out !== e.pow)) begin
        failures++;
        $display("FAIL %s cyc %0d: ftw=%0d done=%0b pow=%0d expected ftw=%0d done=%0b pow=%0d",
                 e.req, cyc, ftw_out, sweep_done, pow_out, e.ftw, e.dn, e.pow);
      end
    end
  end

  task automatic adv();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_until(int t);
    while (cyc < t) adv();
  endtask

  initial begin
    #(CLK_PER * 50000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c;
    for (int i = 0; i < NPROF; i++) begin
      ftw_tab[i] = (i == 0) ? 16'd100 : (i == 1) ? 16'd200 : FTW_W'(1000 + i * 7);
      pow_tab[i] = POW_W'(i * 3 + 1);
      prof_ftw[i*FTW_W +: FTW_W] = ftw_tab[i];
      prof_pow[i*POW_W +: POW_W] = pow_tab[i];
    end
    repeat (3) adv();
    c = cyc;
    push(c + 1, 16'd100, 1'b0, "R3 reset loads lower limit");
    adv();
    rst = 1'b0;
    adv();

    // R1 / R2 single tone over every profile
    for (int s = 0; s < NPROF; s++) begin
      c = cyc;
      prof_sel = SEL_W'(s);
      push_pow(c + 1, ftw_tab[s], pow_tab[s], "R1 R2 single tone");
      adv();
    end
    adv();

    // default sweep upward, R3 R4 R6
    prof_sel = '0;
    adv();
    c = cyc;
    rise_delta = 16'd30; rise_rate = 8'd3;
    fall_delta = 16'd20; fall_rate = 8'd2;
    sweep_en = 1'b1; prof_sel = 1;
    push(c + 1, 16'd100, 1'b0, "R3 entry loads lower");
    push(c + 3, 16'd100, 1'b0, "R4 no early step");
    push(c + 4, 16'd130, 1'b0, "R4 first rising step");
    push(c + 7, 16'd160, 1'b0, "R4 rising step");
    push(c + 10, 16'd190, 1'b0, "R4 rising step");
    push_pow(c + 13, 16'd200, pow_tab[1], "R6 clamp upper / R2 phase");
    push(c + 20, 16'd200, 1'b0, "R6 hold upper");
    wait_until(c + 20);

    // falling then mid-ramp reversal, R5 R7
    c = cyc;
    prof_sel = 0;
    push(c + 1, 16'd200, 1'b0, "R7 restart no step");
    push(c + 2, 16'd180, 1'b0, "R5 falling step");
    push(c + 4, 16'd160, 1'b0, "R5 falling step");
    push(c + 6, 16'd140, 1'b0, "R5 falling step");
    wait_until(c + 6);
    prof_sel = 1;
    push(c + 7, 16'd140, 1'b0, "R7 reversal holds");
    push(c + 8, 16'd140, 1'b0, "R7 reversal holds");
    push(c + 9, 16'd170, 1'b0, "R7 rise from present value");
    wait_until(c + 9);

    // down to lower clamp, R6
    c = cyc;
    prof_sel = 0;
    push(c + 2, 16'd150, 1'b0, "R5 falling step");
    push(c + 6, 16'd110, 1'b0, "R5 falling step");
    push_pow(c + 8, 16'd100, pow_tab[0], "R6 clamp lower");
    push(c + 12, 16'd100, 1'b0, "R6 hold lower");
    wait_until(c + 12);

    // R8 rate zero
    c = cyc;
    rise_rate = 8'd0; prof_sel = 1;
    push(c + 1, 16'd130, 1'b0, "R8 rate zero steps each clock");
    push(c + 2, 16'd160, 1'b0, "R8 rate zero steps each clock");
    push(c + 3, 16'd190, 1'b0, "R8 rate zero steps each clock");
    push(c + 4, 16'd200, 1'b0, "R8 R6 clamp");
    wait_until(c + 4);

    // no-dwell mode, R3 R9 R10
    c = cyc;
    no_dwell = 1'b1; prof_sel = 0; rise_rate = 8'd2; rise_delta = 16'd40;
    push(c + 1, 16'd100, 1'b0, "R3 no-dwell entry");
    push(c + 3, 16'd100, 1'b0, "R11 idle without edge");
    wait_until(c + 3);
    c = cyc;
    prof_sel = 1;
    push(c + 1, 16'd100, 1'b0, "R9 start no step");
    push(c + 3, 16'd140, 1'b0, "R9 first step");
    push(c + 5, 16'd180, 1'b0, "R9 continues after pin fall");
    push(c + 7, 16'd200, 1'b1, "R10 upper with done");
    push(c + 8, 16'd100, 1'b0, "R10 snap to lower");
    push(c + 9, 16'd100, 1'b0, "R10 stays lower");
    wait_until(c + 3);
    prof_sel = 0;
    wait_until(c + 10);

    // R11 held high: one sweep only
    c = cyc;
    prof_sel = 1;
    push(c + 3, 16'd140, 1'b0, "R9 second sweep step");
    push(c + 7, 16'd200, 1'b1, "R10 upper with done");
    push(c + 8, 16'd100, 1'b0, "R10 snap to lower");
    push(c + 14, 16'd100, 1'b0, "R11 no restart while held");
    wait_until(c + 14);
    prof_sel = 0;
    adv();
    c = cyc;
    prof_sel = 1;
    push(c + 3, 16'd140, 1'b0, "R11 fresh edge restarts");
    wait_until(c + 4);

    // back to single tone
    c = cyc;
    sweep_en = 1'b0; no_dwell = 1'b0; prof_sel = 5;
    push_pow(c + 1, ftw_tab[5], pow_tab[5], "R1 R2 return to tone");
    wait_until(c + 3);

    if (sb.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule